// File: doc/BRIEF.md
# Linear Address Breakpoint Unit

This block watches the stream of linear addresses issued by a processor core and compares each valid address against a set of programmable breakpoint slots (four by default). When an address equals a slot whose enable bit is set, the unit requests a debug exception. It also records, in sticky status bits, every slot that matched. The same exception is used for single stepping. While the trace flag is set, each retired instruction raises a step request and sets a dedicated step status bit.

A resume flag masks breakpoint hits for as long as it is held. It has no effect on single stepping. Software programs the slot addresses, the control register and the status register through a single write port. Software clears status bits by writing the status register.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset, `dbg_req` is 0, `stat_q` is 0 and `ctrl_q` is 0.
- R2: When `lin_valid` is 1, `resume_flag` is 0 and `lin_addr` equals slot k, and slot k's enable bit (control bit 2k) is 1, `dbg_req` is 1 in the next cycle and status bit k is set.
- R3: A match on a slot whose enable bit is 0 raises no request and sets no status bit. An enabled slot that does not match also raises no request and sets no status bit.
- R4: While `lin_valid` is 0, `lin_addr` causes no request and no status change.
- R5: When several enabled slots match in the same cycle, every matching status bit is set. Their bits, together with a step cause in the same cycle, are ORed into the status.
- R6: Status bits stay set until software writes the status register (select 5). A write replaces the stored bits. A hit or step in the same cycle as the write is still recorded.
- R7: While `resume_flag` is 1, breakpoint matches raise no request and set no status bit.
- R8: When `trace_flag` and `retire_pulse` are both 1, `dbg_req` is 1 in the next cycle and status bit 14 is set, whatever the value of `resume_flag`. A retire with `trace_flag` at 0 does nothing.
- R9: A write with `wr_en` at 1 loads the register chosen by `wr_sel`: 0 to 3 select the address slots, 4 the 8-bit control register, 5 the status register. The new value applies from the next cycle, and `ctrl_q` reads back the written control value.
- R10: `dbg_vector` always reads 1.
- R11: A single qualifying event produces a `dbg_req` pulse exactly one cycle long. There is no request in any cycle that does not follow an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lin_addr | input | 32 | Linear address being watched |
| lin_valid | input | 1 | Qualifies `lin_addr` this cycle |
| retire_pulse | input | 1 | One instruction retired this cycle |
| trace_flag | input | 1 | Single-step enable |
| resume_flag | input | 1 | Masks breakpoint matches |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0-3 slots, 4 control, 5 status |
| wr_data | input | 32 | Write data |
| dbg_req | output | 1 | Debug exception request pulse |
| dbg_vector | output | 8 | Exception vector number (1) |
| stat_q | output | 16 | Status: bits 0-3 slot hits, bit 14 step |
| ctrl_q | output | 8 | Control: slot k enabled by bit 2k |

## Verification
The assertions assume that `trace_flag`, `resume_flag`, `retire_pulse` and `lin_valid` are stable, clean levels sampled at the rising edge. They also assume that software writes only the selects 0 to 5. The sticky-status property treats any write to select 5 as a legal overwrite. The bench changes every input only on the falling edge and uses only the six defined selects. It clears status before each table entry, so each expected status value depends only on that entry's own stimulus.

// File: rtl/awu_pkg.sv
package awu_pkg;
   localparam int unsigned DBG_VEC_W = 8;
   localparam logic [DBG_VEC_W-1:0] DBG_VEC_NUM = 8'd1;

   // position of the enable bit of slot k inside the control word
   function automatic int unsigned en_pos(input int unsigned k);
      return 2 * k;
   endfunction
endpackage

// File: rtl/awu_slot.sv
module awu_slot #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned IDX    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              lin_valid,
   input  logic [ADDR_W-1:0] lin_addr,
   output logic              hit
);
   localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(IDX);

   logic [ADDR_W-1:0] bp_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         bp_addr_q <= '0;
      else if (wr_en && (wr_sel == MY_SEL))
         bp_addr_q <= wr_data;
   end

   assign hit = lin_valid && (lin_addr == bp_addr_q);
endmodule

// File: rtl/awu_status.sv
module awu_status #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned STAT_W    = 16,
   parameter int unsigned STEP_BIT  = 14,
   parameter bit          HAS_STEP  = 1'b1,
   parameter int unsigned SEL_W     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] bp_set,
   input  logic                 step_set,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [STAT_W-1:0]    wr_data,
   output logic [STAT_W-1:0]    stat_q
);
   localparam logic [SEL_W-1:0]  STAT_SEL  = SEL_W'(NUM_SLOTS + 1);
   localparam logic [STAT_W-1:0] SLOT_MASK = STAT_W'((1 << NUM_SLOTS) - 1);
   localparam logic [STAT_W-1:0] STEP_MASK = HAS_STEP ? STAT_W'(1 << STEP_BIT) : '0;
   localparam logic [STAT_W-1:0] IMPL_MASK = SLOT_MASK | STEP_MASK;

   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] base;
   logic              sw_wr;

   always_comb begin
      set_vec = STAT_W'(bp_set);
      if (step_set)
         set_vec = set_vec | STEP_MASK;
   end

   assign sw_wr = wr_en && (wr_sel == STAT_SEL);
   assign base  = sw_wr ? (wr_data & IMPL_MASK) : stat_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         stat_q <= '0;
      else
         stat_q <= base | set_vec;
   end

   // R6
   sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R5
   set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_set != '0) |=> ((stat_q[NUM_SLOTS-1:0] & $past(bp_set)) == $past(bp_set)));
endmodule

// File: rtl/awu_trigger.sv
module awu_trigger (
   input  logic clk,
   input  logic rst_n,
   input  logic bp_ev,
   input  logic step_ev,
   output logic dbg_req
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         dbg_req <= 1'b0;
      else
         dbg_req <= bp_ev | step_ev;
   end
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned STAT_W    = 16,
   parameter int unsigned STEP_BIT  = 14,
   parameter bit          HAS_STEP  = 1'b1,
   localparam int unsigned CTRL_W   = 2 * NUM_SLOTS,
   localparam int unsigned SEL_W    = $clog2(NUM_SLOTS + 2)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             lin_addr,
   input  logic                          lin_valid,
   input  logic                          retire_pulse,
   input  logic                          trace_flag,
   input  logic                          resume_flag,
   input  logic                          wr_en,
   input  logic [SEL_W-1:0]              wr_sel,
   input  logic [ADDR_W-1:0]             wr_data,
   output logic                          dbg_req,
   output logic [awu_pkg::DBG_VEC_W-1:0] dbg_vector,
   output logic [STAT_W-1:0]             stat_q,
   output logic [CTRL_W-1:0]             ctrl_q
);
   localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NUM_SLOTS);

   // elaboration-time parameter checks
   if (NUM_SLOTS < 1 || NUM_SLOTS > STEP_BIT) begin : g_bad_slots
      $error("NUM_SLOTS must lie between 1 and STEP_BIT");
   end
   if (STAT_W <= STEP_BIT) begin : g_bad_stat
      $error("STAT_W must exceed STEP_BIT");
   end
   if (ADDR_W < STAT_W || ADDR_W < CTRL_W) begin : g_bad_addr
      $error("ADDR_W must cover status and control widths");
   end

   logic [NUM_SLOTS-1:0] slot_hit;
   logic [NUM_SLOTS-1:0] slot_en;
   logic [NUM_SLOTS-1:0] bp_set;
   logic                 step_ev;

   // control register
   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_en && (wr_sel == CTRL_SEL))
         ctrl_q <= wr_data[CTRL_W-1:0];
   end

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      awu_slot #(
         .ADDR_W (ADDR_W),
         .SEL_W  (SEL_W),
         .IDX    (k)
      ) i_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en),
         .wr_sel    (wr_sel),
         .wr_data   (wr_data),
         .lin_valid (lin_valid),
         .lin_addr  (lin_addr),
         .hit       (slot_hit[k])
      );
      assign slot_en[k] = ctrl_q[awu_pkg::en_pos(k)];
   end

   assign bp_set = resume_flag ? '0 : (slot_hit & slot_en);

   if (HAS_STEP) begin : g_step
      assign step_ev = trace_flag && retire_pulse;

      // R8
      step_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (trace_flag && retire_pulse) |=> (dbg_req && stat_q[STEP_BIT]));
   end else begin : g_nostep
      assign step_ev = 1'b0;
   end

   awu_status #(
      .NUM_SLOTS (NUM_SLOTS),
      .STAT_W    (STAT_W),
      .STEP_BIT  (STEP_BIT),
      .HAS_STEP  (HAS_STEP),
      .SEL_W     (SEL_W)
   ) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .bp_set   (bp_set),
      .step_set (step_ev),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data[STAT_W-1:0]),
      .stat_q   (stat_q)
   );

   awu_trigger i_trigger (
      .clk     (clk),
      .rst_n   (rst_n),
      .bp_ev   (|bp_set),
      .step_ev (step_ev),
      .dbg_req (dbg_req)
   );

   assign dbg_vector = awu_pkg::DBG_VEC_NUM;

   // R2
   bp_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(slot_hit & slot_en)) && !resume_flag) |=> dbg_req);

   // R7
   resume_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_flag && !(trace_flag && retire_pulse)) |=> !dbg_req);

   // R11
   no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|(slot_hit & slot_en)) && !(trace_flag && retire_pulse)) |=> !dbg_req);
endmodule

// File: tb/test_addr_watch_unit.sv
module test_addr_watch_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] lin_addr;
   logic        lin_valid, retire_pulse, trace_flag, resume_flag, wr_en;
   logic [2:0]  wr_sel;
   logic [31:0] wr_data;
   logic        dbg_req;
   logic [7:0]  dbg_vector;
   logic [15:0] stat_q;
   logic [7:0]  ctrl_q;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   addr_watch_unit i_addr_watch_unit (
      .clk(clk), .rst_n(rst_n), .lin_addr(lin_addr), .lin_valid(lin_valid),
      .retire_pulse(retire_pulse), .trace_flag(trace_flag), .resume_flag(resume_flag),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .dbg_req(dbg_req),
      .dbg_vector(dbg_vector), .stat_q(stat_q), .ctrl_q(ctrl_q)
   );

   typedef struct packed {
      logic [7:0]  ctrl;
      logic [31:0] addr;
      logic        valid;
      logic        resume;
      logic        trace;
      logic        retire;
      logic        exp_req;
      logic [15:0] exp_stat;
   } vec_t;

   // slots: 0 -> 1000, 1 -> 2000, 2 -> 1000, 3 -> FFFFFFFC
   localparam vec_t VEC [12] = '{
      '{8'h01, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0001}, // R2
      '{8'h10, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0004}, // R2
      '{8'h11, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0005}, // R5
      '{8'h00, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3
      '{8'h04, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3
      '{8'h55, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4
      '{8'h55, 32'h0000_2000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000}, // R7
      '{8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h4000}, // R8
      '{8'h55, 32'h0000_1000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h4000}, // R7 R8
      '{8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000}, // R8
      '{8'h40, 32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0008}, // R2
      '{8'h55, 32'h0000_1000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h4005}  // R5
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle_inputs();
      lin_valid = 1'b0; lin_addr = '0; retire_pulse = 1'b0;
      trace_flag = 1'b0; resume_flag = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
      idle_inputs();
      repeat (3) @(negedge clk);
      // R1 reset state, R10 vector value
      check("R1 req", 32'(dbg_req), 32'h0);
      check("R1 stat", 32'(stat_q), 32'h0);
      check("R1 ctrl", 32'(ctrl_q), 32'h0);
      check("R10 vector", 32'(dbg_vector), 32'h1);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 program slots
      wr(3'd0, 32'h0000_1000);
      wr(3'd1, 32'h0000_2000);
      wr(3'd2, 32'h0000_1000);
      wr(3'd3, 32'hFFFF_FFFC);

      for (int i = 0; i < 12; i++) begin
         wr(3'd4, 32'(VEC[i].ctrl));
         wr(3'd5, 32'h0);
         check("R9 ctrl readback", 32'(ctrl_q), 32'(VEC[i].ctrl));
         lin_addr = VEC[i].addr; lin_valid = VEC[i].valid;
         resume_flag = VEC[i].resume; trace_flag = VEC[i].trace;
         retire_pulse = VEC[i].retire;
         @(negedge clk);
         check($sformatf("vec%0d req", i), 32'(dbg_req), 32'(VEC[i].exp_req));
         check($sformatf("vec%0d stat", i), 32'(stat_q), 32'(VEC[i].exp_stat));
         idle_inputs();
         @(negedge clk);
         check("R11 one-cycle pulse", 32'(dbg_req), 32'h0);
      end

      // R6 sticky then cleared by write
      wr(3'd4, 32'h01);
      wr(3'd5, 32'h0);
      lin_valid = 1'b1; lin_addr = 32'h1000;
      @(negedge clk);
      idle_inputs();
      repeat (4) @(negedge clk);
      check("R6 sticky", 32'(stat_q), 32'h0001);
      wr(3'd5, 32'h0);
      check("R6 cleared", 32'(stat_q), 32'h0);

      // R6 hit wins over same-cycle clear
      wr(3'd5, 32'h0);
      lin_valid = 1'b1; lin_addr = 32'h1000;
      wr(3'd5, 32'h0);
      idle_inputs();
      check("R6 set wins", 32'(stat_q), 32'h0001);

      // R9 slot rewrite takes effect
      wr(3'd5, 32'h0);
      wr(3'd0, 32'h0000_3000);
      lin_valid = 1'b1; lin_addr = 32'h1000;
      @(negedge clk);
      idle_inputs();
      check("R9 old addr gone", 32'(dbg_req), 32'h0);
      lin_valid = 1'b1; lin_addr = 32'h3000;
      @(negedge clk);
      idle_inputs();
      check("R9 new addr hit", 32'(dbg_req), 32'h1);
      check("R9 new addr stat", 32'(stat_q), 32'h0001);
      @(negedge clk);
      check("R11 back low", 32'(dbg_req), 32'h0);
      check("R10 vector", 32'(dbg_vector), 32'h1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule